// File: doc/BRIEF.md
# Shannon-Split Configurable Logic Block

This block is a small programmable logic cell. It can realize any Boolean function of five inputs. The function is split on the most significant input `a`. One 4-input lookup table (`G`) holds the half of the truth table where `a` is 1, and a second 4-input table (`F`) holds the half where `a` is 0. A third, 3-input table (`H`) combines `a` with the two table outputs.

Loaded with a 2:1 multiplexer pattern, `H` produces `p = a·g + a'·f`. Because `H` is a fully programmable 8-entry table, it can also form any other function of `a`, `g` and `f`.

The `H` result reaches the output in one of two ways, chosen by a mode bit. It can pass straight through as a combinational value, or it can go through a flip-flop that has a synchronous clear. All table contents and the mode bit are loaded through a serial shift chain. Bits shift in MSB first while the configuration enable is high.

Top module: `clb3_lut`

## Requirements
- R1: While `cfg_en_i` is 1, each rising clock edge shifts `cfg_di_i` into bit 0 of the 41-bit configuration word, and every older bit moves up one place. Bits are therefore sent MSB first.
  - Word layout: bits [40:25] hold `G`, bits [24:9] hold `F`, bits [8:1] hold `H`, and bit 0 is the output mode.
  - Output mode values: 1 selects the registered output, 0 selects the combinational output.
- R2: With `vars_i = {a,b,c,d,e}` (bit 4 is `a`), `G` and `F` are each addressed by `{b,c,d,e}` = `vars_i[3:0]`. Bit k of a table is its output for address k.
- R3: `H` is addressed by `{a, g, f}`, with `a` as the address MSB. In combinational mode, `out_o` equals `H[{a,g,f}]` for any 8-bit `H` content.
- R4: When the block holds a split truth table, it reproduces that table for all 32 input combinations. The split is `G[k] = T[16+k]`, `F[k] = T[k]` and `H = 8'hCA`.
- R5: In registered mode, `out_o` shows the value of the combinational function as it stood at the previous rising clock edge.
- R6: In registered mode, `sreset_i` = 1 at a rising edge clears `out_o` to 0 after that edge. In combinational mode, `sreset_i` has no effect on `out_o`.
- R7: While `cfg_en_i` is 0, the configuration word does not change, whatever `cfg_di_i` does.
- R8: When `rst_ni` is low, the configuration word and the flip-flop are cleared asynchronously, so `out_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the configuration chain and the output flip-flop |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_di_i | input | 1 | Serial configuration data, MSB first |
| sreset_i | input | 1 | Synchronous clear of the output flip-flop, active high |
| vars_i | input | 5 | Function inputs {a,b,c,d,e}, with a in bit 4 |
| out_o | output | 1 | Block output |

## Verification
The assertions check on every clock cycle that:
- each enabled edge shifts the serial bit into the configuration word, and the word holds when shifting is off;
- the combinational output matches the `H` entry selected by `a` and the two cofactor outputs;
- the registered output lags the combinational value by one edge;
- a synchronous clear empties the flip-flop.

Only the bench scenarios can show the two things that follow. First, that a serial load places each table at its intended bit positions. Second, that the split of random five-input truth tables reproduces all 32 rows in both output modes. The directed cases cover the non-multiplexer `H` pattern, the clear in each mode, and the state after reset.

// File: rtl/clb_pkg.sv
package clb_pkg;
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

  localparam int unsigned H_IN = 3;
endpackage

// File: rtl/lut_table.sv
module lut_table #(
  parameter int unsigned N_IN = 4,
  localparam int unsigned DEPTH = 2 ** N_IN
) (
  input  logic [DEPTH-1:0] table_i,
  input  logic [N_IN-1:0]  addr_i,
  output logic             data_o
);
  assign data_o = table_i[addr_i];
endmodule

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
  parameter int unsigned W = 41
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         di_i,
  output logic [W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (en_i) cfg_o <= {cfg_o[W-2:0], di_i};
  end
endmodule

// File: rtl/clb_out_stage.sv
module clb_out_stage
  import clb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sreset_i,
  input  out_mode_e mode_i,
  input  logic      d_i,
  output logic      q_o
);
  logic ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ff_q <= 1'b0;
    else if (sreset_i) ff_q <= 1'b0;
    else               ff_q <= d_i;
  end

  assign q_o = (mode_i == OUT_REG) ? ff_q : d_i;
endmodule

// File: rtl/clb3_lut.sv
module clb3_lut
  import clb_pkg::*;
#(
  parameter int unsigned K = 4,
  localparam int unsigned N_VARS = K + 1,
  localparam int unsigned T_W    = 2 ** K,
  localparam int unsigned H_W    = 2 ** H_IN,
  localparam int unsigned CFG_W  = 2 * T_W + H_W + 1,
  localparam int unsigned H_LO   = 1,
  localparam int unsigned F_LO   = H_LO + H_W,
  localparam int unsigned G_LO   = F_LO + T_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_di_i,
  input  logic              sreset_i,
  input  logic [N_VARS-1:0] vars_i,
  output logic              out_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       cof_out;   // [1]=g, [0]=f
  logic             g_out, f_out, h_out;
  out_mode_e        mode;

  clb_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .di_i  (cfg_di_i),
    .cfg_o (cfg_q)
  );

  // Cofactor tables: index 1 is G (a=1), index 0 is F (a=0)
  for (genvar i = 0; i < 2; i++) begin : g_cof
    localparam int unsigned LO = (i == 1) ? G_LO : F_LO;
    lut_table #(.N_IN(K)) u_lut (
      .table_i(cfg_q[LO +: T_W]),
      .addr_i (vars_i[K-1:0]),
      .data_o (cof_out[i])
    );
  end

  assign g_out = cof_out[1];
  assign f_out = cof_out[0];

  lut_table #(.N_IN(H_IN)) u_h (
    .table_i(cfg_q[H_LO +: H_W]),
    .addr_i ({vars_i[K], g_out, f_out}),
    .data_o (h_out)
  );

  assign mode = out_mode_e'(cfg_q[0]);

  clb_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sreset_i(sreset_i),
    .mode_i  (mode),
    .d_i     (h_out),
    .q_o     (out_o)
  );
endmodule

// File: rtl/clb3_lut_chk.sv
module clb3_lut_chk #(
  parameter int unsigned K = 4,
  localparam int unsigned CFG_W = 2 * (2 ** K) + 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic             cfg_di_i,
  input logic             sreset_i,
  input logic [K:0]       vars_i,
  input logic             out_o,
  input logic [CFG_W-1:0] cfg_q,
  input logic             g_out,
  input logic             f_out,
  input logic             h_out
);
  assert_shift_in_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_q[0] == $past(cfg_di_i) && cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-2:0]));

  assert_hold_cfg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_q));

  assert_h_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[0] |-> out_o == cfg_q[1 + {vars_i[K], g_out, f_out}]);

  assert_reg_lag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[0] && !sreset_i && !cfg_en_i) |=> out_o == $past(h_out));

  assert_sclear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sreset_i && cfg_q[0] && !cfg_en_i) |=> !out_o);

  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_out_R8: assert (out_o == 1'b0);
  end
endmodule

bind clb3_lut clb3_lut_chk #(.K(K)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cfg_en_i(cfg_en_i),
  .cfg_di_i(cfg_di_i),
  .sreset_i(sreset_i),
  .vars_i  (vars_i),
  .out_o   (out_o),
  .cfg_q   (cfg_q),
  .g_out   (g_out),
  .f_out   (f_out),
  .h_out   (h_out)
);

// File: tb/tb_clb3_lut.sv
`timescale 1ns/1ps
module tb_clb3_lut;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_en_i = 1'b0;
  logic       cfg_di_i = 1'b0;
  logic       sreset_i = 1'b0;
  logic [4:0] vars_i = '0;
  logic       out_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned seed_dummy;

  always #2.5 clk_i = ~clk_i;

  clb3_lut dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_di_i(cfg_di_i),
    .sreset_i(sreset_i), .vars_i(vars_i), .out_o(out_o)
  );

  // Bench model: word = {G[15:0], F[15:0], H[7:0], mode}
  function automatic logic model(input logic [40:0] w, input logic [4:0] v);
    logic g, f;
    g = w[25 + v[3:0]];
    f = w[9 + v[3:0]];
    return w[1 + {v[4], g, f}];
  endfunction

  function automatic logic [40:0] split(input logic [31:0] tt, input logic md);
    return {tt[31:16], tt[15:0], 8'hCA, md};
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: out_o=%b expected %b (vars=%b)", req, got, exp, vars_i);
    end
  endtask

  task automatic load(input logic [40:0] w);
    for (int i = 40; i >= 0; i--) begin
      @(negedge clk_i);
      cfg_en_i = 1'b1;
      cfg_di_i = w[i];
    end
    @(negedge clk_i);
    cfg_en_i = 1'b0;
  endtask

  // Combinational sweep: checks model for all 32 inputs
  task automatic sweep_comb(input logic [40:0] w, input string req);
    for (int v = 0; v < 32; v++) begin
      @(negedge clk_i);
      vars_i = 5'(v);
      #1 check(out_o, model(w, vars_i), req);
    end
  endtask

  task automatic sweep_reg(input logic [40:0] w, input string req);
    for (int v = 0; v < 32; v++) begin
      @(negedge clk_i);
      vars_i = 5'(v);
      @(posedge clk_i);
      #1 check(out_o, model(w, 5'(v)), req);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [40:0] w;
    logic [31:0] tt;
    logic        prev;
    seed_dummy = $urandom(32'd465);

    // R8: reset state, config cleared so output 0
    repeat (3) @(negedge clk_i);
    for (int v = 0; v < 32; v += 7) begin
      vars_i = 5'(v);
      #1 check(out_o, 1'b0, "R8 during reset");
      @(negedge clk_i);
    end
    rst_ni = 1'b1;

    // R1/R2/R3: directed non-mux H (xor of a,g,f), distinct G/F
    w = {16'hFFFF, 16'h6996, 8'h96, 1'b0};
    load(w);
    sweep_comb(w, "R3 xor H");
    w = {16'h8001, 16'h0F0F, 8'hE8, 1'b0};  // majority of a,g,f
    load(w);
    sweep_comb(w, "R1 R2 majority H");

    // R4/R5: random split truth tables, both modes
    for (int t = 0; t < 8; t++) begin
      tt = $urandom;
      w = split(tt, 1'b0);
      load(w);
      sweep_comb(w, "R4 comb");
      w = split(tt, 1'b1);
      load(w);
      sweep_reg(w, "R5 reg");
    end
    // corner tables
    w = split(32'h0000_0000, 1'b0); load(w); sweep_comb(w, "R4 all0");
    w = split(32'hFFFF_FFFF, 1'b1); load(w); sweep_reg(w, "R4 all1 reg");
    w = split(32'h0000_0001, 1'b0); load(w); sweep_comb(w, "R4 single minterm");

    // R7: shift data toggles with enable low, config unchanged
    w = split(32'hA5C3_5A3C, 1'b0);
    load(w);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      cfg_di_i = 1'($urandom);
    end
    sweep_comb(w, "R7 hold");

    // R6: sreset in registered mode clears, in comb mode no effect
    w = split(32'hFFFF_FFFF, 1'b1);
    load(w);
    @(negedge clk_i); vars_i = 5'd3;
    @(posedge clk_i); #1 check(out_o, 1'b1, "R6 pre-clear");
    @(negedge clk_i); sreset_i = 1'b1;
    @(posedge clk_i); #1 check(out_o, 1'b0, "R6 reg clear");
    @(negedge clk_i); sreset_i = 1'b0;
    @(posedge clk_i); #1 check(out_o, 1'b1, "R6 reg resume");
    w = split(32'hFFFF_FFFF, 1'b0);
    load(w);
    @(negedge clk_i); sreset_i = 1'b1;
    @(posedge clk_i); #1 check(out_o, 1'b1, "R6 comb unaffected");
    @(negedge clk_i); sreset_i = 1'b0;

    // R8: async reset mid-run clears config
    @(negedge clk_i); #1 prev = out_o;
    check(prev, 1'b1, "R8 before reset");
    rst_ni = 1'b0;
    #1 check(out_o, 1'b0, "R8 async clear");
    @(negedge clk_i); rst_ni = 1'b1;
    #1 check(out_o, 1'b0, "R8 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule